// File: doc/BRIEF.md
# Page-Mode DRAM Access Sequencer

This block sits between a synchronous word-request port and an asynchronous dynamic memory of 1M x 4 bits. The memory multiplexes its 10 row and 10 column address bits onto one 10-pin address bus. Each accepted request carries a 20-bit word address, a direction flag and a 4-bit write nibble. The block opens the addressed row by pulling the row strobe low. It then runs the column access with the column strobe, and it leaves the row open afterwards. A later request to the same row costs only a column-strobe cycle. A request to another row, a refresh request or an exhausted row-open budget closes the row first.

Every timing limit is a parameter counted in clock cycles: row-address hold, row-to-column delay, column-strobe low and high widths, row precharge, maximum row-open time and read sample delay. The column address goes onto the bus as soon as the row hold has passed, so the memory's column latch can start the access before the column strobe falls. Read data is captured at the end of the column-low phase. That phase is stretched to cover the slowest of the memory's access paths. An external refresh arbiter gets the bus through a request/grant pair once the row is closed and precharged.

Top module: `pgdram_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the row strobe, column strobe, write strobe and output enable are all high (inactive). The data-drive enable, `done_valid` and `ref_gnt` are low, and `req_ready` is low.
- R2: The row is `req_addr[19:10]` and is on `mem_addr` when the row strobe falls. The column is `req_addr[9:0]` and is on `mem_addr` when the column strobe falls.
- R3: A read (`req_write`=0) holds the write strobe high and the output enable low while the column strobe is low. It returns the nibble that was last written to that address on `done_rdata`, with `done_valid` high for exactly one cycle.
- R4: A write (`req_write`=1) is an early write. The write strobe is low and `mem_dq_out` is driven with the data-drive enable high before the column strobe falls. The output enable stays high for the whole access. `done_rdata` is 0 for a write.
- R5: A request to the row that is already open is served by a column-strobe cycle alone, with no new row-strobe fall.
- R6: A request to a different row raises the row strobe. The row strobe then stays high for at least T_RP cycles before it falls again.
- R7: The column strobe falls at least T_RCD cycles after the row strobe falls. It stays low for at least max(T_CAS, T_RD) cycles, and between page accesses it stays high for at least T_CP cycles.
- R8: The column address is on `mem_addr` for at least one full cycle before the column strobe falls. During the column-low phase, `mem_addr` and the write strobe do not change.
- R9: The row strobe is never low for more than T_RAS_MAX consecutive cycles. An open row is closed on time even during a stream of same-row requests or while no request arrives.
- R10: `ref_req` closes any open row. `ref_gnt` rises exactly T_RP cycles after the row strobe rises, and only while both strobes are high. No request is accepted while `ref_req` is high or in the cycle after it is released.
- R11: A request is taken in a cycle with `req_valid` and `req_ready` both high. Each taken request produces exactly one `done_valid` pulse, in request order.
- R12: The column strobe is low only while the row strobe is low. The data-drive enable is never high while the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 4 | Write nibble |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 4 | Read nibble (0 for writes) |
| ref_req | input | 1 | Refresh arbiter asks for the bus |
| ref_gnt | output | 1 | Bus released to the refresh arbiter |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 4 | Write data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 4 | Read data from the memory |

## Verification
The first access to a closed row starts one cycle after acceptance. From there it costs T_RAH cycles of row phase, max(T_RCD−T_RAH,1) cycles of column setup and max(T_CAS,T_RD) cycles of column-low phase, and `done_valid` appears in the cycle the column strobe rises. A page hit costs one setup cycle plus the column-low phase, and a refresh grant arrives T_RP cycles after the row closes. The bench's memory model takes every timing and ordering measurement on the falling clock edge, half a cycle after the design's registers change. It gives read data only once the column strobe has been low for T_RD cycles. The scoreboard monitor pops an expected item only when it sees `done_valid`, so results are compared in the cycle they are due and never before.

// File: rtl/pgdram_pkg.sv
`timescale 1ns/1ps
package pgdram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,   // row closed, precharging or waiting
        PH_ROW  = 3'd1,   // row strobe low, row address held
        PH_COLA = 3'd2,   // column address on bus, column strobe high
        PH_CAS  = 3'd3,   // column strobe low
        PH_OPEN = 3'd4    // row open, column strobe high
    } phase_e;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/pgdram_dly.sv
`timescale 1ns/1ps
module pgdram_dly #(
    parameter int unsigned W       = 4,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= W'(RST_VAL);
        else if (ld)            cnt_q <= ld_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pgdram_rasmon.sv
`timescale 1ns/1ps
module pgdram_rasmon
    import pgdram_pkg::*;
#(
    parameter int unsigned T_RAS_MAX = 40,
    parameter int unsigned LIMIT     = 36
) (
    input  logic clk,
    input  logic rst,
    input  logic row_open,
    output logic budget_ok
);
    localparam int unsigned W = cnt_bits(T_RAS_MAX);

    // cycles the row has already been open before the current one
    logic [W-1:0] open_q;

    always_ff @(posedge clk) begin
        if (rst || !row_open)               open_q <= '0;
        else if (open_q != W'(T_RAS_MAX))   open_q <= open_q + 1'b1;
    end

    assign budget_ok = (open_q < W'(LIMIT));
endmodule

// File: rtl/pgdram_ctl.sv
`timescale 1ns/1ps
module pgdram_ctl
    import pgdram_pkg::*;
#(
    parameter int unsigned ROW_W = 10,
    parameter int unsigned COL_W = 10,
    parameter int unsigned DQ_W  = 4,
    parameter int unsigned T_RAH = 1,
    parameter int unsigned T_RCD = 3,
    parameter int unsigned T_CAS = 2,
    parameter int unsigned T_CP  = 1,
    parameter int unsigned T_RD  = 2,
    parameter int unsigned SW    = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [ROW_W+COL_W-1:0]    req_addr,
    input  logic [DQ_W-1:0]           req_wdata,
    output logic                      done_valid,
    output logic [DQ_W-1:0]           done_rdata,
    input  logic                      ref_req,
    output logic                      ref_gnt,
    input  logic                      step_zero,
    input  logic                      rp_zero,
    input  logic                      budget_ok,
    output logic                      step_ld,
    output logic [SW-1:0]             step_val,
    output logic                      rp_ld,
    output logic                      row_open,
    output logic [imax(ROW_W,COL_W)-1:0] mem_addr,
    output logic                      mem_ras_n,
    output logic                      mem_cas_n,
    output logic                      mem_we_n,
    output logic                      mem_oe_n,
    output logic [DQ_W-1:0]           mem_dq_out,
    output logic                      mem_dq_oe,
    input  logic [DQ_W-1:0]           mem_dq_in
);
    localparam int unsigned MW         = imax(ROW_W, COL_W);
    localparam int unsigned CAS_LOW    = imax(T_CAS, T_RD);
    localparam int unsigned FIRST_COLA = (T_RCD > T_RAH) ? (T_RCD - T_RAH) : 1;

    typedef struct packed {
        logic             wr;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  wdata;
    } acc_t;

    phase_e state_q, state_d;
    acc_t   cur_q;
    logic   gnt_q;
    logic   take;
    logic   row_hit;
    logic   done_q;
    logic [DQ_W-1:0] rdata_q;

    assign row_hit = (req_addr[ROW_W+COL_W-1 -: ROW_W] == cur_q.row);

    always_comb begin
        state_d   = state_q;
        step_ld   = 1'b0;
        step_val  = '0;
        rp_ld     = 1'b0;
        take      = 1'b0;
        req_ready = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                req_ready = rp_zero && !ref_req && !gnt_q;
                if (gnt_q && !ref_req) rp_ld = 1'b1;
                if (req_ready && req_valid) begin
                    take     = 1'b1;
                    state_d  = PH_ROW;
                    step_ld  = 1'b1;
                    step_val = SW'(T_RAH - 1);
                end
            end
            PH_ROW: if (step_zero) begin
                state_d  = PH_COLA;
                step_ld  = 1'b1;
                step_val = SW'(FIRST_COLA - 1);
            end
            PH_COLA: if (step_zero) begin
                state_d  = PH_CAS;
                step_ld  = 1'b1;
                step_val = SW'(CAS_LOW - 1);
            end
            PH_CAS: if (step_zero) begin
                state_d  = PH_OPEN;
                step_ld  = 1'b1;
                step_val = SW'(T_CP - 1);
            end
            PH_OPEN: begin
                req_ready = step_zero && !ref_req && budget_ok && row_hit;
                if (ref_req || !budget_ok) begin
                    state_d = PH_IDLE;
                    rp_ld   = 1'b1;
                end else if (step_zero && req_valid) begin
                    if (row_hit) begin
                        take     = 1'b1;
                        state_d  = PH_COLA;
                        step_ld  = 1'b1;
                        step_val = '0;
                    end else begin
                        state_d = PH_IDLE;
                        rp_ld   = 1'b1;
                    end
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_IDLE;
            cur_q   <= '0;
            gnt_q   <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            gnt_q   <= ref_gnt;
            if (take) begin
                cur_q.wr    <= req_write;
                cur_q.row   <= req_addr[ROW_W+COL_W-1 -: ROW_W];
                cur_q.col   <= req_addr[COL_W-1:0];
                cur_q.wdata <= req_wdata;
            end
            done_q <= (state_q == PH_CAS) && step_zero;
            if ((state_q == PH_CAS) && step_zero)
                rdata_q <= cur_q.wr ? '0 : mem_dq_in;
        end
    end

    // strobe and bus decode from the registered phase
    logic col_phase;
    assign col_phase  = (state_q == PH_COLA) || (state_q == PH_CAS);
    assign row_open   = (state_q != PH_IDLE);
    assign mem_ras_n  = !row_open;
    assign mem_cas_n  = (state_q != PH_CAS);
    assign mem_we_n   = !(col_phase && cur_q.wr);
    assign mem_dq_oe  = col_phase && cur_q.wr;
    assign mem_oe_n   = !((state_q == PH_CAS) && !cur_q.wr);
    assign mem_dq_out = cur_q.wdata;
    assign mem_addr   = (state_q == PH_ROW)  ? MW'(cur_q.row) :
                        (state_q == PH_IDLE) ? '0 : MW'(cur_q.col);
    assign ref_gnt    = (state_q == PH_IDLE) && rp_zero && ref_req;
    assign done_valid = done_q;
    assign done_rdata = rdata_q;
endmodule

// File: rtl/pgdram_seq.sv
`timescale 1ns/1ps
module pgdram_seq
    import pgdram_pkg::*;
#(
    parameter int unsigned ROW_W     = 10,
    parameter int unsigned COL_W     = 10,
    parameter int unsigned DQ_W      = 4,
    parameter int unsigned T_RAH     = 1,
    parameter int unsigned T_RCD     = 3,
    parameter int unsigned T_CAS     = 2,
    parameter int unsigned T_CP      = 1,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RAS_MAX = 40,
    parameter int unsigned T_RD      = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic [ROW_W+COL_W-1:0]        req_addr,
    input  logic [DQ_W-1:0]               req_wdata,
    output logic                          done_valid,
    output logic [DQ_W-1:0]               done_rdata,
    input  logic                          ref_req,
    output logic                          ref_gnt,
    output logic [imax(ROW_W,COL_W)-1:0]  mem_addr,
    output logic                          mem_ras_n,
    output logic                          mem_cas_n,
    output logic                          mem_we_n,
    output logic                          mem_oe_n,
    output logic [DQ_W-1:0]               mem_dq_out,
    output logic                          mem_dq_oe,
    input  logic [DQ_W-1:0]               mem_dq_in
);
    localparam int unsigned CAS_LOW = imax(T_CAS, T_RD);
    localparam int unsigned SW      = cnt_bits(imax(imax(T_RAH, T_RCD), imax(CAS_LOW, T_CP)));
    localparam int unsigned PW      = cnt_bits(T_RP);
    // last open-row count at which one more page access still fits
    localparam int unsigned LIMIT   = T_RAS_MAX - 2 - CAS_LOW;

    logic          step_ld, step_zero;
    logic [SW-1:0] step_val;
    logic          rp_ld, rp_zero;
    logic          row_open, budget_ok;

    pgdram_dly #(.W(SW), .RST_VAL(0)) u_step (
        .clk(clk), .rst(rst), .ld(step_ld), .ld_val(step_val), .zero(step_zero)
    );

    pgdram_dly #(.W(PW), .RST_VAL(T_RP - 1)) u_prech (
        .clk(clk), .rst(rst), .ld(rp_ld), .ld_val(PW'(T_RP - 1)), .zero(rp_zero)
    );

    pgdram_rasmon #(.T_RAS_MAX(T_RAS_MAX), .LIMIT(LIMIT)) u_rasmon (
        .clk(clk), .rst(rst), .row_open(row_open), .budget_ok(budget_ok)
    );

    pgdram_ctl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
        .T_RAH(T_RAH), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RD(T_RD),
        .SW(SW)
    ) u_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done_valid(done_valid), .done_rdata(done_rdata),
        .ref_req(ref_req), .ref_gnt(ref_gnt),
        .step_zero(step_zero), .rp_zero(rp_zero), .budget_ok(budget_ok),
        .step_ld(step_ld), .step_val(step_val), .rp_ld(rp_ld), .row_open(row_open),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );
endmodule

// File: rtl/pgdram_seq_chk.sv
`timescale 1ns/1ps
module pgdram_seq_chk #(
    parameter int unsigned MW        = 10,
    parameter int unsigned T_RP      = 3,
    parameter int unsigned T_RAS_MAX = 40
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_ras_n,
    input logic          mem_cas_n,
    input logic          mem_we_n,
    input logic          mem_oe_n,
    input logic          mem_dq_oe,
    input logic [MW-1:0] mem_addr,
    input logic          ref_gnt,
    input logic          done_valid
);
    logic [15:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else begin
            lo_cnt <= mem_ras_n ? '0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1);
            hi_cnt <= !mem_ras_n ? '0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1);
        end
    end

    // R12
    cas_in_row_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_cas_n |-> !mem_ras_n);

    // R12
    bus_contend_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n);

    // R4
    early_write_hiz_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && !mem_cas_n) |-> mem_oe_n);

    // R8
    cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_cas_n && $past(!mem_cas_n)) |-> ($stable(mem_addr) && $stable(mem_we_n)));

    // R10
    gnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ref_gnt |-> (mem_ras_n && mem_cas_n));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    // R9
    ras_window_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ras_n |-> (lo_cnt < 16'(T_RAS_MAX)));

    // R6
    precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_ras_n) |-> (hi_cnt >= 16'(T_RP)));
endmodule

bind pgdram_seq pgdram_seq_chk #(
    .MW(pgdram_pkg::imax(ROW_W, COL_W)), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
    .clk(clk), .rst(rst), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe),
    .mem_addr(mem_addr), .ref_gnt(ref_gnt), .done_valid(done_valid)
);

// File: tb/pgdram_seq_bench.sv
`timescale 1ns/1ps
module pgdram_seq_bench;
    localparam int unsigned RAH = 1, RCD = 3, CASW = 2, CP = 1, RP = 3, RASMAX = 40, RD = 2;
    localparam int unsigned CASLOW = (CASW > RD) ? CASW : RD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, done_valid, ref_gnt;
    logic [3:0]  done_rdata;
    logic [9:0]  mem_addr;
    logic        mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [3:0]  mem_dq_out;
    logic [3:0]  mem_dq_in = '0;

    pgdram_seq #(.T_RAH(RAH), .T_RCD(RCD), .T_CAS(CASW), .T_CP(CP), .T_RP(RP),
                 .T_RAS_MAX(RASMAX), .T_RD(RD)) u_pgdram_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .done_valid(done_valid), .done_rdata(done_rdata),
        .ref_req(ref_req), .ref_gnt(ref_gnt),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_tests = 0, n_fail = 0, n_taken = 0, n_done = 0, ras_falls = 0, cyc = 0;

    typedef struct { bit wr; logic [3:0] data; string tag; } exp_t;
    exp_t        exp_q[$];
    logic [19:0] acc_q[$];
    logic [3:0]  dmem [int unsigned];
    logic [3:0]  rmem [int unsigned];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] seed(input logic [19:0] a);
        return a[3:0] ^ a[13:10] ^ 4'h5;
    endfunction

    // ---------------- memory model ----------------
    bit pr_ras = 1, pr_cas = 1, first_col = 1, m_rd = 0;
    int ras_lo = 0, ras_hi = 0, cas_lo = 0, cas_hi = 0;
    logic [9:0] mrow = '0, mcol = '0, prev_addr = '0;
    logic [3:0] m_data = '0;
    bit prev_we = 1;

    always @(negedge clk) begin
        if (rst) begin
            pr_ras = 1; pr_cas = 1; ras_lo = 0; ras_hi = 0; cas_lo = 0; cas_hi = 0; m_rd = 0;
        end else begin
            if (pr_ras && !mem_ras_n) begin
                ras_falls++;
                check(ras_hi >= RP, "R6", "row strobe high cycles", ras_hi, RP);
                mrow = mem_addr;
                first_col = 1;
            end
            if (!pr_ras && mem_ras_n)
                check(ras_lo <= RASMAX, "R9", "row strobe low cycles", ras_lo, RASMAX);
            if (pr_cas && !mem_cas_n) begin
                logic [19:0] a;
                check(!mem_ras_n, "R12", "column strobe outside row", mem_ras_n, 0);
                if (first_col) check(ras_lo >= RCD, "R7", "row-to-column cycles", ras_lo, RCD);
                else           check(cas_hi >= CP, "R7", "column high cycles", cas_hi, CP);
                first_col = 0;
                check(prev_addr == mem_addr, "R8", "column address setup", prev_addr, mem_addr);
                mcol = mem_addr;
                a = {mrow, mcol};
                if (acc_q.size() != 0) begin
                    logic [19:0] e;
                    e = acc_q.pop_front();
                    check(a == e, "R2", "row/column address", a, e);
                end else check(0, "R11", "column access without request", a, 0);
                if (!mem_we_n) begin
                    check(mem_dq_oe && mem_oe_n && !prev_we, "R4", "early write drive/oe/we",
                          {mem_dq_oe, mem_oe_n, prev_we}, 3'b110);
                    dmem[a] = mem_dq_out;
                    m_rd = 0;
                end else begin
                    m_rd = 1;
                    m_data = dmem.exists(a) ? dmem[a] : seed(a);
                end
            end
            if (!pr_cas && !mem_cas_n && (prev_addr != mem_addr || prev_we != mem_we_n))
                check(0, "R8", "address/write strobe moved in column phase", mem_addr, prev_addr);
            if (!pr_cas && mem_cas_n) begin
                check(cas_lo >= CASLOW, "R7", "column low cycles", cas_lo, CASLOW);
                m_rd = 0;
            end
            if (mem_dq_oe && !mem_oe_n)
                check(0, "R12", "drive enable with output enable", 1, 0);
            ras_lo = mem_ras_n ? 0 : ras_lo + 1;
            ras_hi = mem_ras_n ? ras_hi + 1 : 0;
            cas_lo = mem_cas_n ? 0 : cas_lo + 1;
            cas_hi = mem_cas_n ? cas_hi + 1 : 0;
            prev_addr = mem_addr; prev_we = mem_we_n;
            pr_ras = mem_ras_n; pr_cas = mem_cas_n;
        end
        mem_dq_in = (m_rd && !mem_cas_n && !mem_oe_n && cas_lo >= RD) ? m_data : ~m_data;
    end

    // ---------------- scoreboard monitor ----------------
    always @(negedge clk) begin
        if (!rst && done_valid) begin
            n_done++;
            if (exp_q.size() == 0) check(0, "R11", "completion without request", 1, 0);
            else begin
                exp_t e;
                e = exp_q.pop_front();
                check(done_rdata == e.data, e.tag, e.wr ? "write completion data" : "read data",
                      done_rdata, e.data);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input logic [19:0] a, input logic [3:0] d, input string tag);
        exp_t e;
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        e.wr = wr; e.tag = tag;
        if (wr) begin rmem[a] = d; e.data = 4'h0; end
        else e.data = rmem.exists(a) ? rmem[a] : seed(a);
        exp_q.push_back(e);
        acc_q.push_back(a);
        n_taken++;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R11", "completions outstanding", exp_q.size(), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int f0, k;
        repeat (3) @(negedge clk);
        check({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe, done_valid, ref_gnt} == 7'b1111000,
              "R1", "strobes in reset", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe, done_valid, ref_gnt},
              7'b1111000);
        rst = 0;
        @(negedge clk); #1;
        check(req_ready == 0 && mem_ras_n && mem_cas_n, "R1", "ready after reset", req_ready, 0);

        // write then read back (R4, R3)
        issue(1, 20'h12345, 4'h9, "R4");
        issue(0, 20'h12345, 4'h0, "R3");
        // unwritten address on another row (R3, R6)
        issue(0, 20'hABC07, 4'h0, "R3");
        drain();

        // page hits on the open row (R5)
        f0 = ras_falls;
        issue(1, 20'hABC10, 4'h3, "R5");
        issue(1, 20'hABC11, 4'hC, "R5");
        issue(0, 20'hABC10, 4'h0, "R5");
        issue(0, 20'hABC11, 4'h0, "R5");
        issue(0, 20'hABC07, 4'h0, "R5");
        drain();
        check(ras_falls == f0, "R5", "row strobe falls during page hits", ras_falls - f0, 0);

        // long same-row stream must be split by the open-row limit (R9)
        f0 = ras_falls;
        for (int i = 0; i < 14; i++) issue(i[0], {10'h055, 10'(i)}, 4'(i + 1), "R9");
        drain();
        check(ras_falls - f0 >= 2, "R9", "row reopened during long stream", ras_falls - f0, 2);

        // row miss closes and reopens (R6)
        f0 = ras_falls;
        issue(0, {10'h2AA, 10'h003}, 4'h0, "R6");
        drain();
        check(ras_falls - f0 == 1, "R6", "row strobe falls on miss", ras_falls - f0, 1);

        // refresh hand-off (R10)
        ref_req = 1;
        k = 0;
        while (!ref_gnt && k < 50) begin @(negedge clk); k++; end
        check(k == RP, "R10", "cycles to grant", k, RP);
        check(mem_ras_n && mem_cas_n, "R10", "strobes at grant", {mem_ras_n, mem_cas_n}, 2'b11);
        req_valid = 1; req_write = 0; req_addr = {10'h2AA, 10'h003};
        for (int i = 0; i < 4; i++) begin
            #1; check(!req_ready && ref_gnt, "R10", "ready during grant", req_ready, 0);
            @(negedge clk);
        end
        ref_req = 0;
        #1; check(!req_ready, "R10", "ready on release", req_ready, 0);
        @(negedge clk);
        f0 = ras_falls;
        issue(0, {10'h2AA, 10'h003}, 4'h0, "R10");
        drain();
        check(ras_falls - f0 == 1, "R10", "row reopened after refresh", ras_falls - f0, 1);

        // final read of earlier data across rows (R3) and completion count (R11)
        issue(0, 20'h12345, 4'h0, "R3");
        issue(0, 20'hABC11, 4'h0, "R3");
        drain();
        check(n_done == n_taken, "R11", "completions vs requests", n_done, n_taken);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule